// File: doc/BRIEF.md
# Timer Interrupt Edge-to-Pending Converter

This block sits between the per-core timer and watchdog units and an interrupt distributor. Each core owns two level-sensitive interrupt lines: a timer line and a watchdog line. The block samples every line on each clock and keeps the sampled level. When a line goes from low to high, the block raises a set-pending request for a private interrupt that belongs to the core owning that line. The request is a single-cycle strobe that carries a core index and a 5-bit interrupt number.

The lines are packed in pairs. Line `i` belongs to core `i >> 1`. Bit 0 of `i` selects the source: the timer when it is 0, the watchdog when it is 1. Timers map to private interrupt 29 and watchdogs to private interrupt 30. There are exactly `2*NUM_CORES` input lines. No line exists for a "current core" alias slot.

Several lines can rise in the same cycle. Each rising edge is therefore latched into a pending flag for its line. The flags are drained at one request per cycle, lowest line index first, so no edge is dropped. The request for an edge seen at clock edge `t` can go out in the same register stage, so an edge that is not competing with other lines appears on the outputs right after clock edge `t`.

Top module: `tedp_top`

## Requirements
- R1: An active-low asynchronous reset clears every stored line level and every pending flag, and drives `req_valid_o` to 0. A line that is already high when reset is released is therefore seen as a rising edge at the first sample.
- R2: A low-to-high transition on a line, when no other request is pending or competing, gives `req_valid_o = 1` for exactly one cycle. The strobe appears on the outputs right after the clock edge that first samples the line high.
- R3: A line that stays high, stays low or falls produces no request. With no pending flags and no rising line, `req_valid_o` is 0 in the next cycle.
- R4: A request for line `i` carries `req_core_o = i >> 1`, which is always less than `NUM_CORES`.
- R5: A request for an even line carries `req_irq_o = 29` (timer). A request for an odd line carries `req_irq_o = 30` (watchdog).
- R6: When several lines are pending or rising together, one request is issued per cycle, in increasing line-index order. `req_valid_o` stays high for as long as any flag is pending.
- R7: No edge is lost. Edges on `k` distinct lines yield exactly `k` requests, one per line, followed by an idle output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_lvl_i | input | 2*NUM_CORES | Interrupt levels; line i is core i>>1, bit 0 of i picks timer (0) or watchdog (1) |
| req_valid_o | output | 1 | One-cycle set-pending strobe |
| req_core_o | output | CORE_W | Target core of the request |
| req_irq_o | output | 5 | Private interrupt number (29 or 30) |

## Verification
The checker covers several properties on every cycle. It checks that a rising line or a non-empty backlog always yields a strobe in the next cycle. It checks that an idle input with an empty backlog yields none. It also checks that the core index and interrupt number stay in range, and that reset clears the backlog and the strobe. Some properties are visible only through the bench's directed scenarios, which compare exact output sequences: the exact line-to-core and line-to-number mapping, lowest-first ordering across a full burst, the total count of requests matching the count of edges, and the handling of a line held high across reset.

// File: rtl/tedp_pkg.sv
package tedp_pkg;
    localparam int IRQ_W        = 5;
    localparam int IRQ_TIMER_ID = 29;
    localparam int IRQ_WDOG_ID  = 30;
endpackage

// File: rtl/tedp_edge.sv
module tedp_edge #(
    parameter int N = 8
) (
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] prev_i,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        assign rise_o[g] = lvl_i[g] & ~prev_i[g];
    end
endmodule

// File: rtl/tedp_pick.sv
module tedp_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [N-1:0]     grant_o
);
    always_comb begin
        any_o   = 1'b0;
        idx_o   = '0;
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o   = 1'b1;
                idx_o   = IDX_W'(i);
                grant_o = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/tedp_top.sv
module tedp_top #(
    parameter  int NUM_CORES = 4,
    localparam int NUM_LINES = 2 * NUM_CORES,
    localparam int LINE_W    = $clog2(NUM_LINES),
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [NUM_LINES-1:0]       line_lvl_i,
    output logic                       req_valid_o,
    output logic [CORE_W-1:0]          req_core_o,
    output logic [tedp_pkg::IRQ_W-1:0] req_irq_o
);
    import tedp_pkg::*;

    typedef struct packed {
        logic [NUM_LINES-1:0] prev;
        logic [NUM_LINES-1:0] pend;
        logic                 valid;
        logic [CORE_W-1:0]    core;
        logic [IRQ_W-1:0]     irq;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] cand;
    logic [NUM_LINES-1:0] grant;
    logic [LINE_W-1:0]    win_idx;
    logic                 win_any;

    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] pend_q;
    assign prev_q = st_q.prev;
    assign pend_q = st_q.pend;

    tedp_edge #(.N(NUM_LINES)) u_edge (
        .lvl_i  (line_lvl_i),
        .prev_i (st_q.prev),
        .rise_o (rise)
    );

    assign cand = st_q.pend | rise;

    tedp_pick #(.N(NUM_LINES), .IDX_W(LINE_W)) u_pick (
        .req_i   (cand),
        .any_o   (win_any),
        .idx_o   (win_idx),
        .grant_o (grant)
    );

    always_comb begin
        st_d       = st_q;
        st_d.prev  = line_lvl_i;
        st_d.pend  = cand & ~grant;
        st_d.valid = win_any;
        st_d.core  = '0;
        st_d.irq   = '0;
        if (win_any) begin
            st_d.core = CORE_W'(win_idx >> 1);
            st_d.irq  = win_idx[0] ? IRQ_W'(IRQ_WDOG_ID) : IRQ_W'(IRQ_TIMER_ID);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid_o = st_q.valid;
    assign req_core_o  = st_q.core;
    assign req_irq_o   = st_q.irq;
endmodule

// File: rtl/tedp_chk.sv
module tedp_chk #(
    parameter  int NUM_CORES = 4,
    localparam int NUM_LINES = 2 * NUM_CORES,
    localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_LINES-1:0] line_lvl_i,
    input logic [NUM_LINES-1:0] prev_q,
    input logic [NUM_LINES-1:0] pend_q,
    input logic                 req_valid_o,
    input logic [CORE_W-1:0]    req_core_o,
    input logic [4:0]           req_irq_o
);
    // R1: reset empties the backlog and silences the strobe
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            p_reset_clear_r1: assert (pend_q == '0 && !req_valid_o)
                else $error("reset did not clear state");
        end
    end

    p_edge_served_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(line_lvl_i & ~prev_q)) |=> req_valid_o);

    p_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q == '0 && (line_lvl_i & ~prev_q) == '0) |=> !req_valid_o);

    p_core_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> (int'(req_core_o) < NUM_CORES));

    p_irq_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o |-> (req_irq_o == 5'd29 || req_irq_o == 5'd30));

    p_backlog_drains_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q != '0) |=> req_valid_o);
endmodule

bind tedp_top tedp_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_lvl_i  (line_lvl_i),
    .prev_q      (prev_q),
    .pend_q      (pend_q),
    .req_valid_o (req_valid_o),
    .req_core_o  (req_core_o),
    .req_irq_o   (req_irq_o)
);

// File: tb/tb_tedp_top.sv
module tb_tedp_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NL = 2 * NC;
    localparam int NVEC = 14;

    // {lines, exp_valid, exp_core, exp_irq}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'b0000_0000, 1'b0, 2'd0, 5'd0},
        {8'b0000_0001, 1'b1, 2'd0, 5'd29},
        {8'b0000_0001, 1'b0, 2'd0, 5'd0},
        {8'b0000_0000, 1'b0, 2'd0, 5'd0},
        {8'b0000_1000, 1'b1, 2'd1, 5'd30},
        {8'b0000_1000, 1'b0, 2'd0, 5'd0},
        {8'b1000_1000, 1'b1, 2'd3, 5'd30},
        {8'b0000_0000, 1'b0, 2'd0, 5'd0},
        {8'b0001_0110, 1'b1, 2'd0, 5'd30},
        {8'b0001_0110, 1'b1, 2'd1, 5'd29},
        {8'b0000_0000, 1'b1, 2'd2, 5'd29},
        {8'b0000_0000, 1'b0, 2'd0, 5'd0},
        {8'b0100_0000, 1'b1, 2'd3, 5'd29},
        {8'b0000_0000, 1'b0, 2'd0, 5'd0}
    };

    logic          clk_i = 1'b0;
    logic          rst_ni;
    logic [NL-1:0] line_lvl_i = '0;
    logic          req_valid_o;
    logic [1:0]    req_core_o;
    logic [4:0]    req_irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    tedp_top #(.NUM_CORES(NC)) dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .line_lvl_i  (line_lvl_i),
        .req_valid_o (req_valid_o),
        .req_core_o  (req_core_o),
        .req_irq_o   (req_irq_o)
    );

    task automatic check(input string req, input logic ev,
                         input logic [1:0] ec, input logic [4:0] ei);
        bit bad;
        n_chk++;
        bad = (req_valid_o !== ev) || (ev && (req_core_o !== ec || req_irq_o !== ei));
        if (bad) begin
            n_bad++;
            $display("FAIL %s: got v=%0b core=%0d irq=%0d, expected v=%0b core=%0d irq=%0d",
                     req, req_valid_o, req_core_o, req_irq_o, ev, ec, ei);
        end
    endtask

    task automatic step(input logic [NL-1:0] lv);
        line_lvl_i = lv;
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    initial begin
        rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        // R1: reset state
        check("R1", 1'b0, 2'd0, 5'd0);
        rst_ni = 1'b1;

        // Table walk: R2 single pulse, R3 steady/fall silent, R4/R5 mapping, R6 order
        for (int k = 0; k < NVEC; k++) begin
            step(VEC[k][15:8]);
            check($sformatf("R2/R3/R4/R5/R6 vec%0d", k), VEC[k][7], VEC[k][6:5], VEC[k][4:0]);
        end

        // R7 + R6: all lines rise together; eight requests lowest first, then idle
        step(8'hFF);
        check("R7 line0", 1'b1, 2'd0, 5'd29);
        for (int j = 1; j < NL; j++) begin
            step(8'hFF);
            check($sformatf("R6 burst line%0d", j), 1'b1, 2'(j >> 1),
                  (j % 2 == 1) ? 5'd30 : 5'd29);
        end
        step(8'hFF);
        check("R7 burst done", 1'b0, 2'd0, 5'd0);
        step(8'h00);
        check("R3 all fall", 1'b0, 2'd0, 5'd0);

        // R1: reset mid-backlog discards pending flags
        step(8'hF0);
        check("R1 pre-reset line4", 1'b1, 2'd2, 5'd29);
        line_lvl_i = 8'h00;
        rst_ni = 1'b0;
        @(negedge clk_i);
        check("R1 in reset", 1'b0, 2'd0, 5'd0);
        rst_ni = 1'b1;
        step(8'h00);
        check("R1 backlog cleared a", 1'b0, 2'd0, 5'd0);
        step(8'h00);
        check("R1 backlog cleared b", 1'b0, 2'd0, 5'd0);

        // R1: line held high across reset release counts as an edge
        rst_ni = 1'b0;
        line_lvl_i = 8'b0010_0000;
        @(negedge clk_i);
        rst_ni = 1'b1;
        step(8'b0010_0000);
        check("R1 held-high line5", 1'b1, 2'd2, 5'd30);
        step(8'b0010_0000);
        check("R3 held high", 1'b0, 2'd0, 5'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule